// File: doc/BRIEF.md
# Synchronous Exception Priority Resolver

This block gathers every synchronous exception request raised by one instruction of a RISC-V style hart and reduces them to one trap. It picks the request with the highest fixed priority. It then produces three results: a trap-valid flag, the cause word written into the machine cause register, and the trap-value payload for the handler. Interrupt arbitration, the exception program counter and privilege changes are handled elsewhere.

Each request input is one bit in a single vector, with one bit per exception source. Next to the vector sit the following:

- a load/store direction flag;
- the current privilege level;
- the fetch virtual address;
- the data virtual address, which is the address of the part that faulted for split accesses;
- the raw instruction bits;
- the software-check code.

The priority order is not monotonic in the cause codes. A parameter moves the load/store misaligned check from the bottom of the order to just above data translation faults. A second parameter adds one output register stage.

Top module: `exc_resolve`

## Requirements
- R1: Request bits of `exc_req` map to causes as follows, written as bit:code. 0 fetch breakpoint:3. 1 fetch translation page fault:12. 2 fetch translation access fault:1. 3 fetch physical access fault:1. 4 illegal instruction:2. 5 fetch misaligned:0. 6 environment call:see R5. 7 environment break:3. 8 software check:18. 9 data breakpoint:3. 10 data translation page fault:13 or 15. 11 data translation access fault:5 or 7. 12 data physical access fault:5 or 7. 13 data misaligned:4 or 6.
- R2: With MISAL_EARLY=0, when several bits are set, the lowest-numbered set bit wins.
- R3: With MISAL_EARLY=1, bit 13 ranks directly after bit 9 and ahead of bits 10, 11 and 12. All other bits keep the R2 order.
- R4: For bits 10 to 13, `mem_is_store`=1 selects the store/AMO codes (15, 7, 7, 6) and 0 selects the load codes (13, 5, 5, 4).
- R5: An environment call reports code 8 when `cur_priv`=0, code 9 when `cur_priv`=1, and code 11 when `cur_priv` is 2 or 3.
- R6: For bits 0, 1, 2, 3, 5 and 7, the trap value is `fetch_vaddr`. For bits 9 to 13, it is `mem_vaddr`.
- R7: For an illegal instruction, the trap value is `insn_bits` zero-extended to XLEN.
- R8: For a software check, the trap value is `chk_code` zero-extended to XLEN.
- R9: An environment call gives a trap value of zero.
- R10: When no request bit is set, `trap_valid` is 0 and both `trap_cause` and `trap_tval` are 0.
- R11: The most significant bit of `trap_cause` is always 0, and the code sits in the low bits.
- R12: With OUT_REG=1, results appear one clock after their inputs. All outputs are 0 during and straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 14 | One request bit per exception source |
| mem_is_store | input | 1 | Data access is a store, SC or AMO |
| cur_priv | input | 2 | Privilege level that raised an environment call |
| fetch_vaddr | input | XLEN | Fetch virtual address |
| mem_vaddr | input | XLEN | Data virtual address of the faulting part |
| insn_bits | input | ILEN | Raw instruction bits |
| chk_code | input | SWC_W | Software-check code (2 landing pad, 3 shadow stack) |
| trap_valid | output | 1 | An exception was taken |
| trap_cause | output | XLEN | Cause word |
| trap_tval | output | XLEN | Trap-value payload |

## Verification
The hardest cases to reach are collisions where the winner's payload comes from a different source than the loser's. One example is an illegal instruction against a data fault, where the two would select the instruction bits and the data address. Another is data misaligned against data translation faults, where the order depends on the parameter. The stimulus applies every single request and every pair of requests, each under both load and store direction. Instances built with both parameter settings run side by side. A bit-walk over the privilege levels and a set of triples with distinct fetch and data addresses complete the run, so a payload taken from the wrong source shows up at once.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int unsigned NSRC   = 14;
    localparam int unsigned CODE_W = 5;

    // request bit positions, in default priority order
    localparam int unsigned S_FBKPT = 0;
    localparam int unsigned S_FXPF  = 1;
    localparam int unsigned S_FXAF  = 2;
    localparam int unsigned S_FPAF  = 3;
    localparam int unsigned S_ILL   = 4;
    localparam int unsigned S_FMIS  = 5;
    localparam int unsigned S_ECALL = 6;
    localparam int unsigned S_EBRK  = 7;
    localparam int unsigned S_SWCHK = 8;
    localparam int unsigned S_MBKPT = 9;
    localparam int unsigned S_MXPF  = 10;
    localparam int unsigned S_MXAF  = 11;
    localparam int unsigned S_MPAF  = 12;
    localparam int unsigned S_MMIS  = 13;

    typedef enum logic [2:0] {
        PL_ZERO, PL_FADDR, PL_MADDR, PL_INSN, PL_CHK
    } payload_e;

    // rank position -> source bit; early variant lifts data misaligned
    function automatic int unsigned rank_src(int unsigned k, bit early);
        if (!early || k < S_MXPF) return k;
        if (k == S_MXPF)          return S_MMIS;
        return k - 1;
    endfunction

    function automatic logic [CODE_W-1:0] src_code(int unsigned s, logic st,
                                                  logic [1:0] priv);
        case (s)
            S_FBKPT: return 5'd3;
            S_FXPF:  return 5'd12;
            S_FXAF:  return 5'd1;
            S_FPAF:  return 5'd1;
            S_ILL:   return 5'd2;
            S_FMIS:  return 5'd0;
            S_ECALL: return (priv == 2'd0) ? 5'd8 : (priv == 2'd1) ? 5'd9 : 5'd11;
            S_EBRK:  return 5'd3;
            S_SWCHK: return 5'd18;
            S_MBKPT: return 5'd3;
            S_MXPF:  return st ? 5'd15 : 5'd13;
            S_MXAF:  return st ? 5'd7 : 5'd5;
            S_MPAF:  return st ? 5'd7 : 5'd5;
            default: return st ? 5'd6 : 5'd4;
        endcase
    endfunction

    function automatic payload_e src_payload(int unsigned s);
        case (s)
            S_FBKPT, S_FXPF, S_FXAF, S_FPAF, S_FMIS, S_EBRK: return PL_FADDR;
            S_ILL:   return PL_INSN;
            S_SWCHK: return PL_CHK;
            S_ECALL: return PL_ZERO;
            default: return PL_MADDR;
        endcase
    endfunction

endpackage

// File: rtl/exc_first_pick.sv
module exc_first_pick #(
    parameter int unsigned N = 14
) (
    input  logic [N-1:0] vec,
    output logic [N-1:0] onehot,
    output logic         any
);
    always_comb begin
        logic found;
        found  = 1'b0;
        onehot = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (vec[i] && !found) begin
                onehot[i] = 1'b1;
                found     = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/exc_payload.sv
module exc_payload
    import exc_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned ILEN  = 32,
    parameter int unsigned SWC_W = 4
) (
    input  logic [NSRC-1:0]   grant,
    input  logic              is_store,
    input  logic [1:0]        priv,
    input  logic [XLEN-1:0]   fva,
    input  logic [XLEN-1:0]   mva,
    input  logic [ILEN-1:0]   insn,
    input  logic [SWC_W-1:0]  chk,
    output logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   tval
);
    always_comb begin
        code = '0;
        tval = '0;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (grant[i]) begin
                code = code | src_code(i, is_store, priv);
                case (src_payload(i))
                    PL_FADDR: tval = tval | fva;
                    PL_MADDR: tval = tval | mva;
                    PL_INSN:  tval = tval | XLEN'(insn);
                    PL_CHK:   tval = tval | XLEN'(chk);
                    default:  tval = tval;
                endcase
            end
        end
    end
endmodule

// File: rtl/exc_resolve.sv
module exc_resolve
    import exc_pkg::*;
#(
    parameter int unsigned XLEN        = 64,
    parameter int unsigned ILEN        = 32,
    parameter int unsigned SWC_W       = 4,
    parameter bit          MISAL_EARLY = 1'b0,
    parameter bit          OUT_REG     = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  exc_req,
    input  logic             mem_is_store,
    input  logic [1:0]       cur_priv,
    input  logic [XLEN-1:0]  fetch_vaddr,
    input  logic [XLEN-1:0]  mem_vaddr,
    input  logic [ILEN-1:0]  insn_bits,
    input  logic [SWC_W-1:0] chk_code,
    output logic             trap_valid,
    output logic [XLEN-1:0]  trap_cause,
    output logic [XLEN-1:0]  trap_tval
);
    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
    } res_t;

    logic [NSRC-1:0]   ordered, ord_grant, grant;
    logic              any_req;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   payload;
    res_t              res_d, res_q;

    // rank permutation fixed at elaboration
    for (genvar k = 0; k < NSRC; k++) begin : g_rank
        localparam int unsigned SRC = rank_src(k, MISAL_EARLY);
        assign ordered[k] = exc_req[SRC];
        assign grant[SRC] = ord_grant[k];
    end

    exc_first_pick #(.N(NSRC)) u_pick (
        .vec    (ordered),
        .onehot (ord_grant),
        .any    (any_req)
    );

    exc_payload #(.XLEN(XLEN), .ILEN(ILEN), .SWC_W(SWC_W)) u_pay (
        .grant    (grant),
        .is_store (mem_is_store),
        .priv     (cur_priv),
        .fva      (fetch_vaddr),
        .mva      (mem_vaddr),
        .insn     (insn_bits),
        .chk      (chk_code),
        .code     (code),
        .tval     (payload)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = any_req;
        // interrupt flag in the MSB stays clear for exceptions
        res_d.cause = {1'b0, (XLEN-1)'(code)};
        res_d.tval  = payload;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign trap_valid = res_q.valid;
    assign trap_cause = res_q.cause;
    assign trap_tval  = res_q.tval;
endmodule

// File: rtl/exc_resolve_chk.sv
module exc_resolve_chk
    import exc_pkg::*;
#(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned ILEN    = 32,
    parameter bit          OUT_REG = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] exc_req,
    input logic [XLEN-1:0] fetch_vaddr,
    input logic [ILEN-1:0] insn_bits,
    input logic            trap_valid,
    input logic [XLEN-1:0] trap_cause,
    input logic [XLEN-1:0] trap_tval
);
    logic [NSRC-1:0] o_req;
    logic [XLEN-1:0] o_fva;
    logic [ILEN-1:0] o_insn;
    logic            o_ok;

    if (OUT_REG) begin : g_dly
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                o_req <= '0; o_fva <= '0; o_insn <= '0; o_ok <= 1'b0;
            end else begin
                o_req <= exc_req; o_fva <= fetch_vaddr; o_insn <= insn_bits; o_ok <= 1'b1;
            end
        end
    end else begin : g_now
        assign o_req  = exc_req;
        assign o_fva  = fetch_vaddr;
        assign o_insn = insn_bits;
        assign o_ok   = 1'b1;
    end

    assert_valid_iff_req_R10: assert property (@(posedge clk) disable iff (!rst_n || !o_ok)
        trap_valid == (o_req != '0));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n || !o_ok)
        (o_req == '0) |-> (trap_cause == '0 && trap_tval == '0));

    assert_msb_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_cause[XLEN-1]);

    assert_fetch_bkpt_top_R2: assert property (@(posedge clk) disable iff (!rst_n || !o_ok)
        o_req[0] |-> (trap_cause == XLEN'(3) && trap_tval == o_fva));

    assert_illegal_bits_R7: assert property (@(posedge clk) disable iff (!rst_n || !o_ok)
        (o_req[3:0] == '0 && o_req[4]) |-> (trap_cause == XLEN'(2) && trap_tval == XLEN'(o_insn)));

    assert_ecall_zero_R9: assert property (@(posedge clk) disable iff (!rst_n || !o_ok)
        (o_req[5:0] == '0 && o_req[6]) |-> (trap_tval == '0));
endmodule

bind exc_resolve exc_resolve_chk #(.XLEN(XLEN), .ILEN(ILEN), .OUT_REG(OUT_REG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_req     (exc_req),
    .fetch_vaddr (fetch_vaddr),
    .insn_bits   (insn_bits),
    .trap_valid  (trap_valid),
    .trap_cause  (trap_cause),
    .trap_tval   (trap_tval)
);

// File: tb/exc_resolve_test.sv
module exc_resolve_test;
    localparam int XL = 64;
    localparam int IL = 32;
    localparam int NS = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] req = '0;
    logic          st = 1'b0;
    logic [1:0]    priv = 2'd0;
    logic [XL-1:0] fva = 64'h0000_0040_1000_0002;
    logic [XL-1:0] mva = 64'h0000_7fff_0000_0ffd;
    logic [IL-1:0] insn = 32'h8000_0073;
    logic [3:0]    chk = 4'd2;

    logic          v0, v1;
    logic [XL-1:0] c0, c1, t0, t1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    exc_resolve #(.MISAL_EARLY(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .exc_req(req), .mem_is_store(st), .cur_priv(priv),
        .fetch_vaddr(fva), .mem_vaddr(mva), .insn_bits(insn), .chk_code(chk),
        .trap_valid(v0), .trap_cause(c0), .trap_tval(t0));

    exc_resolve #(.MISAL_EARLY(1'b1)) uut_alt (
        .clk(clk), .rst_n(rst_n), .exc_req(req), .mem_is_store(st), .cur_priv(priv),
        .fetch_vaddr(fva), .mem_vaddr(mva), .insn_bits(insn), .chk_code(chk),
        .trap_valid(v1), .trap_cause(c1), .trap_tval(t1));

    typedef struct {
        bit          v;
        logic [XL-1:0] c;
        logic [XL-1:0] t;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];

    // behavioural reference: an explicit priority list walked in order
    function automatic exp_t model(bit early);
        exp_t e;
        int order[$];
        int win = -1;
        for (int k = 0; k < NS; k++) order.push_back(k);
        if (early) begin
            order.delete(13);
            order.insert(10, 13);
        end
        foreach (order[i]) if (win < 0 && req[order[i]]) win = order[i];
        e.v = (win >= 0); e.c = '0; e.t = '0;
        case (win)
            0:  begin e.c = 3;  e.t = fva; end
            1:  begin e.c = 12; e.t = fva; end
            2:  begin e.c = 1;  e.t = fva; end
            3:  begin e.c = 1;  e.t = fva; end
            4:  begin e.c = 2;  e.t = {32'd0, insn}; end
            5:  begin e.c = 0;  e.t = fva; end
            6:  e.c = (priv == 0) ? 8 : (priv == 1) ? 9 : 11;
            7:  begin e.c = 3;  e.t = fva; end
            8:  begin e.c = 18; e.t = {60'd0, chk}; end
            9:  begin e.c = 3;  e.t = mva; end
            10: begin e.c = st ? 15 : 13; e.t = mva; end
            11: begin e.c = st ? 7 : 5;   e.t = mva; end
            12: begin e.c = st ? 7 : 5;   e.t = mva; end
            13: begin e.c = st ? 6 : 4;   e.t = mva; end
            default: ;
        endcase
        return e;
    endfunction

    task automatic check(string tag, bit vv, logic [XL-1:0] cc, logic [XL-1:0] tt, exp_t e);
        total++;
        if (vv !== e.v || cc !== e.c || tt !== e.t) begin
            bad++;
            $display("FAIL %s req=%h st=%0d: got v=%0d c=%h t=%h exp v=%0d c=%h t=%h",
                     tag, req, st, vv, cc, tt, e.v, e.c, e.t);
        end
    endtask

    // drive at negedge, compare after the next rising edge
    task automatic apply(logic [NS-1:0] r, logic s, logic [1:0] p, string tag);
        @(negedge clk);
        req = r; st = s; priv = p;
        q0.push_back(model(1'b0));
        q1.push_back(model(1'b1));
        @(posedge clk); #1;
        check({tag, " base"}, v0, c0, t0, q0.pop_front());
        check({tag, " early"}, v1, c1, t1, q1.pop_front());
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exp_t z;
        z.v = 1'b0; z.c = '0; z.t = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R12 reset", v0, c0, t0, z);
        check("R12 reset", v1, c1, t1, z);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R12 after reset", v0, c0, t0, z);

        apply('0, 1'b0, 2'd0, "R10 idle");

        // singles: codes, direction and payloads
        for (int s = 0; s < 2; s++)
            for (int b = 0; b < NS; b++)
                apply(NS'(1) << b, s[0], 2'd0, "R1 R4 R6 R7 R11 single");

        // environment call under each privilege
        for (int p = 0; p < 4; p++) apply(NS'(1) << 6, 1'b0, p[1:0], "R5 R9 ecall");

        // software-check codes
        chk = 4'd3; apply(NS'(1) << 8, 1'b0, 2'd0, "R8 shadow");
        chk = 4'd2; apply(NS'(1) << 8, 1'b0, 2'd0, "R8 landing");

        // every pair, both directions
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < NS; a++)
                for (int b = a + 1; b < NS; b++)
                    apply((NS'(1) << a) | (NS'(1) << b), s[0], 2'd1, "R2 R3 pair");

        // explicit misaligned-vs-translation collisions
        apply(14'h2400, 1'b1, 2'd0, "R3 mis vs pf");
        apply(14'h3800, 1'b0, 2'd0, "R3 mis vs af");

        // triples with moved addresses
        fva = 64'hffff_ffc0_0000_1001; mva = 64'h0000_0000_8000_0007; insn = 32'hffff_ffff;
        for (int a = 0; a < NS - 2; a++)
            apply((NS'(1) << a) | (NS'(1) << (a + 1)) | (NS'(1) << (a + 2)), a[0], 2'd3,
                  "R2 R6 R7 triple");
        apply(14'h3fff, 1'b1, 2'd2, "R2 all");
        apply('0, 1'b1, 2'd2, "R10 idle again");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule